// File: doc/BRIEF.md
# Serial Audio Clock Divider Chain

This block produces the timing for a synchronous serial audio port. A network (oversampling) clock, delivered as a one-cycle tick in the peripheral clock domain, passes through a prescaler to form the bit clock. A bit counter marks the end of every word. A word counter, stepped once per completed word, closes each frame and raises a frame sync pulse on the first bit of the following frame. The bit clock and the frame sync can each be taken from an external pin instead of being made inside. In master synchronous operation the raw network clock can be forwarded on an output.

Word length and frame length are held in shadow registers. A change made while the block runs is applied only at the next frame boundary. Dropping the enable returns every counter and the frame state machine to idle.

The frame state machine has six states. `FS_OFF` is idle. `FS_FILL` counts the first frame after enable, with no sync. `FS_PEND` waits for the first bit of a new frame. `FS_SYNC` drives the sync pulse for one bit. `FS_BODY` covers the rest of the frame. `FS_EXT` follows an external frame sync pin. The transitions are:

- OFF→FILL or OFF→EXT on enable, chosen by the frame source.
- FILL→PEND and BODY→PEND when the last word of a frame completes.
- PEND→SYNC on a bit start. The shadow registers load here.
- SYNC→BODY on the next bit start.
- FILL, PEND, SYNC or BODY → EXT when the frame source turns external.
- EXT→FILL when the frame source turns internal.
- Any state → OFF when enable drops.

Top module: `sac_clock_chain`

## Requirements
- R1: `wl_sel` selects the word length: 0→8, 1→10, 2→12, 3→16, 4→18, 5→20, 6→22, 7→24 bits. `word_stb_o` is a one-cycle pulse during the last bit of every word, so one pulse appears per word length of bits.
- R2: `frm_m1` (0..31) sets the frame to `frm_m1`+1 words. Under internal frame timing, successive rising edges of `fs_o` are exactly word length × frame words bit periods apart.
- R3: After enable, no frame sync appears during the first frame. `fs_o` is high for exactly one bit period and rises at the start of the first bit of each later frame.
- R4: With the internal bit clock, one bit period is 2 × (`pm`+1) × (8 if `psr` else 1) network ticks, and `bclk_o` is high for half of it.
- R5: With `bclk_int`=0, bits are timed by rising edges of `ext_bclk`, and `bclk_o` follows the pin after a two-flop synchronizer.
- R6: With `fs_int`=0, `fs_o` follows `ext_fs` within four cycles. A rising edge of the pin restarts the bit count, so the next word strobe follows about one word later.
- R7: `nclk_o` equals `net_clk` when `en`, `bclk_int`, `fs_int`, `sync_mode` and `nclk_oe` are all 1, and is 0 otherwise.
- R8: `cfg_err_o` is 1 when enabled with the internal bit clock and 2 × (`pm`+1) × (8 if `psr` else 1) is below 5, and is 0 otherwise.
- R9: Changes of `wl_sel` or `frm_m1` during a frame leave that frame's length unchanged and apply from the next frame.
- R10: While `en` is 0, `bclk_o`, `word_stb_o` and `fs_o` stay 0 and all counters are cleared.
- R11: During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable; 0 clears all counters |
| net_clk | input | 1 | Network clock level, used for forwarding |
| net_tick | input | 1 | One-cycle pulse per network clock period |
| wl_sel | input | 3 | Word length code (see R1) |
| psr | input | 1 | Adds a fixed divide-by-8 ahead of the modulus divider |
| pm | input | 8 | Prescaler modulus; divides by `pm`+1 |
| frm_m1 | input | 5 | Frame length in words minus one |
| bclk_int | input | 1 | 1: internal bit clock, 0: external pin |
| fs_int | input | 1 | 1: internal frame sync, 0: external pin |
| sync_mode | input | 1 | Synchronous operation |
| nclk_oe | input | 1 | Network clock output enable |
| ext_bclk | input | 1 | External bit clock pin |
| ext_fs | input | 1 | External frame sync pin |
| bclk_o | output | 1 | Bit clock |
| word_stb_o | output | 1 | Word boundary strobe |
| fs_o | output | 1 | Frame sync |
| nclk_o | output | 1 | Forwarded network clock |
| cfg_err_o | output | 1 | Bit clock too fast for the peripheral clock |

## Verification
The hardest case to reach from the ports is a word length or frame length change that lands in the middle of a running frame. It must not alter that frame and must alter the next one. The stimulus waits for a frame sync edge, lets ten cycles pass, rewrites both fields, and then times two consecutive frame intervals. The first interval must match the old settings and the second the new ones. The external frame sync restart is reached in a similar way: the pin is raised at an arbitrary bit phase, and the delay to the next word strobe is bounded by one word.

// File: rtl/sac_pkg.sv
package sac_pkg;

    localparam int WL_SEL_W = 3;
    localparam int WCNT_W   = 5;

    typedef enum logic [2:0] {
        FS_OFF,
        FS_FILL,
        FS_PEND,
        FS_SYNC,
        FS_BODY,
        FS_EXT
    } fs_state_e;

    // Maps the word length code onto the number of bits per word.
    function automatic logic [WCNT_W-1:0] word_len(input logic [WL_SEL_W-1:0] sel);
        logic [WCNT_W-1:0] n;
        unique case (sel)
            3'd0: n = 5'd8;
            3'd1: n = 5'd10;
            3'd2: n = 5'd12;
            3'd3: n = 5'd16;
            3'd4: n = 5'd18;
            3'd5: n = 5'd20;
            3'd6: n = 5'd22;
            3'd7: n = 5'd24;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/sac_sync.sv
module sac_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    generate
        if (STAGES <= 1) begin : g_one
            logic ff;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ff <= 1'b0;
                else        ff <= d;
            end
            assign q = ff;
        end else begin : g_chain
            logic [STAGES-1:0] ff;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ff <= '0;
                else        ff <= {ff[STAGES-2:0], d};
            end
            assign q = ff[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/sac_prescaler.sv
module sac_prescaler #(
    parameter int PM_W        = 8,
    parameter int PSR_DIV     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            net_tick,
    input  logic            psr,
    input  logic [PM_W-1:0] pm,
    input  logic            int_sel,
    input  logic            ext_bclk,
    output logic            bclk,
    output logic            bt
);

    localparam int PSR_W = (PSR_DIV > 1) ? $clog2(PSR_DIV) : 1;

    logic [PSR_W-1:0] pcnt;
    logic [PM_W-1:0]  mcnt;
    logic             bclk_q;
    logic             bt_q;
    logic             stage1;
    logic             toggle;
    logic             run;
    logic             eb;
    logic             eb_d;

    assign run    = en && int_sel;
    assign stage1 = psr ? (net_tick && (pcnt == PSR_W'(PSR_DIV - 1))) : net_tick;
    assign toggle = stage1 && (mcnt >= pm);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt   <= '0;
            mcnt   <= '0;
            bclk_q <= 1'b0;
            bt_q   <= 1'b0;
        end else if (!run) begin
            pcnt   <= '0;
            mcnt   <= '0;
            bclk_q <= 1'b0;
            bt_q   <= 1'b0;
        end else begin
            if (psr && net_tick)
                pcnt <= (pcnt == PSR_W'(PSR_DIV - 1)) ? '0 : pcnt + 1'b1;
            if (stage1)
                mcnt <= toggle ? '0 : mcnt + 1'b1;
            if (toggle)
                bclk_q <= ~bclk_q;
            bt_q <= toggle && !bclk_q;
        end
    end

    sac_sync #(.STAGES(SYNC_STAGES)) u_bsync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ext_bclk),
        .q     (eb)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eb_d <= 1'b0;
        else        eb_d <= eb;
    end

    assign bclk = int_sel ? bclk_q : (en && eb);
    assign bt   = int_sel ? bt_q   : (en && eb && !eb_d);

    // R4: a bit start is never followed by another in the next cycle
    a_r4_bt_single: assert property (@(posedge clk) disable iff (!rst_n)
        bt_q |=> !bt_q);

    // R10: a disabled prescaler holds its clock low and its divider at zero
    a_r10_pre_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!bclk_q && mcnt == '0 && pcnt == '0));

endmodule

// File: rtl/sac_framer.sv
module sac_framer
    import sac_pkg::*;
#(
    parameter int FRM_W       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                bt,
    input  logic [WL_SEL_W-1:0] wl_sel,
    input  logic [FRM_W-1:0]    frm_m1,
    input  logic                fs_int,
    input  logic                ext_fs,
    output logic                word_stb,
    output logic                fs
);

    fs_state_e           state;
    fs_state_e           nxt;
    logic [WCNT_W-1:0]   cnt;
    logic [FRM_W-1:0]    wcnt;
    logic [WL_SEL_W-1:0] wl_sh;
    logic [FRM_W-1:0]    fm_sh;
    logic                stb_q;
    logic                fq;
    logic                fq_d;
    logic                ext_rise;
    logic                frame_done;
    logic                restart;
    logic                last_bit;
    logic [WCNT_W-1:0]   wl_cur;

    sac_sync #(.STAGES(SYNC_STAGES)) u_fsync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ext_fs),
        .q     (fq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fq_d <= 1'b0;
        else        fq_d <= fq;
    end

    assign ext_rise   = fq && !fq_d;
    assign wl_cur     = word_len(wl_sh);
    assign last_bit   = (cnt == wl_cur - 5'd1);
    assign frame_done = stb_q && (wcnt == fm_sh);
    assign restart    = (state == FS_EXT) && ext_rise;

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            FS_OFF:  nxt = fs_int ? FS_FILL : FS_EXT;
            FS_FILL: if (!fs_int) nxt = FS_EXT;
                     else if (frame_done) nxt = FS_PEND;
            FS_PEND: if (!fs_int) nxt = FS_EXT;
                     else if (bt) nxt = FS_SYNC;
            FS_SYNC: if (!fs_int) nxt = FS_EXT;
                     else if (bt) nxt = FS_BODY;
            FS_BODY: if (!fs_int) nxt = FS_EXT;
                     else if (frame_done) nxt = FS_PEND;
            FS_EXT:  if (fs_int) nxt = FS_FILL;
            default: nxt = FS_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state <= FS_OFF;
        else if (!en) state <= FS_OFF;
        else          state <= nxt;
    end

    // Counters and shadow configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            wcnt  <= '0;
            stb_q <= 1'b0;
            wl_sh <= '0;
            fm_sh <= '0;
        end else if (!en) begin
            cnt   <= '0;
            wcnt  <= '0;
            stb_q <= 1'b0;
            wl_sh <= wl_sel;
            fm_sh <= frm_m1;
        end else begin
            if (restart) begin
                cnt  <= '0;
                wcnt <= '0;
            end else begin
                if (bt)
                    cnt <= last_bit ? '0 : cnt + 1'b1;
                if (stb_q)
                    wcnt <= frame_done ? '0 : wcnt + 1'b1;
            end
            stb_q <= bt && !restart && last_bit;
            if (restart || (state == FS_PEND && bt)) begin
                wl_sh <= wl_sel;
                fm_sh <= frm_m1;
            end
        end
    end

    // Outputs
    always_comb begin
        word_stb = stb_q;
        fs       = (state == FS_SYNC) || (state == FS_EXT && fq);
    end

    // R1: the bit index never reaches the word length
    a_r1_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < wl_cur);

    // R1: the word strobe lasts one cycle
    a_r1_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
        stb_q |=> !stb_q);

    // R2: the word index stays inside the frame
    a_r2_wcnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        wcnt <= fm_sh);

    // R3: an internal sync rises right after a bit start
    a_r3_fs_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fs) && state == FS_SYNC) |-> $past(bt));

    // R9: shadow word length stays fixed inside the frame body
    a_r9_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FS_BODY) |-> $stable(wl_sh));

    // R10: disabling clears the machine and counters
    a_r10_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == FS_OFF && cnt == '0 && wcnt == '0));

endmodule

// File: rtl/sac_clock_chain.sv
module sac_clock_chain
    import sac_pkg::*;
#(
    parameter int PM_W         = 8,
    parameter int FRM_W        = 5,
    parameter int PSR_DIV      = 8,
    parameter int SYNC_STAGES  = 2,
    parameter int MIN_BCLK_CYC = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                net_clk,
    input  logic                net_tick,
    input  logic [WL_SEL_W-1:0] wl_sel,
    input  logic                psr,
    input  logic [PM_W-1:0]     pm,
    input  logic [FRM_W-1:0]    frm_m1,
    input  logic                bclk_int,
    input  logic                fs_int,
    input  logic                sync_mode,
    input  logic                nclk_oe,
    input  logic                ext_bclk,
    input  logic                ext_fs,
    output logic                bclk_o,
    output logic                word_stb_o,
    output logic                fs_o,
    output logic                nclk_o,
    output logic                cfg_err_o
);

    localparam int DIV_W = PM_W + $clog2(PSR_DIV + 1) + 2;

    logic             bt;
    logic [DIV_W-1:0] half;
    logic             fwd_en;

    sac_prescaler #(
        .PM_W        (PM_W),
        .PSR_DIV     (PSR_DIV),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .net_tick (net_tick),
        .psr      (psr),
        .pm       (pm),
        .int_sel  (bclk_int),
        .ext_bclk (ext_bclk),
        .bclk     (bclk_o),
        .bt       (bt)
    );

    sac_framer #(
        .FRM_W       (FRM_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_frm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .bt       (bt),
        .wl_sel   (wl_sel),
        .frm_m1   (frm_m1),
        .fs_int   (fs_int),
        .ext_fs   (ext_fs),
        .word_stb (word_stb_o),
        .fs       (fs_o)
    );

    // Half bit period in network ticks for the internal divider
    assign half = (DIV_W'(pm) + DIV_W'(1)) * (psr ? DIV_W'(PSR_DIV) : DIV_W'(1));

    assign cfg_err_o = en && bclk_int && ((half << 1) < DIV_W'(MIN_BCLK_CYC));

    assign fwd_en = en && bclk_int && fs_int && sync_mode && nclk_oe;
    assign nclk_o = net_clk && fwd_en;

endmodule

// File: tb/tb_sac_clock_chain.sv
`timescale 1ns/1ps
module tb_sac_clock_chain;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       en;
    logic       net_clk;
    logic       net_tick = 1'b0;
    logic [2:0] wl_sel;
    logic       psr;
    logic [7:0] pm;
    logic [4:0] frm_m1;
    logic       bclk_int;
    logic       fs_int;
    logic       sync_mode;
    logic       nclk_oe;
    logic       ext_bclk = 1'b0;
    logic       ext_fs;
    logic       bclk_o;
    logic       word_stb_o;
    logic       fs_o;
    logic       nclk_o;
    logic       cfg_err_o;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    int net_div = 1;
    int ndc    = 0;
    bit ext_run = 1'b0;
    int ext_half = 5;
    int ebc    = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc++;

    // Network tick generator
    always @(negedge clk) begin
        if (ndc >= net_div - 1) begin
            ndc = 0;
            net_tick = 1'b1;
        end else begin
            ndc++;
            net_tick = 1'b0;
        end
    end

    // External bit clock generator
    always @(negedge clk) begin
        if (ext_run) begin
            if (ebc == ext_half - 1) begin
                ebc = 0;
                ext_bclk = ~ext_bclk;
            end else ebc++;
        end else begin
            ebc = 0;
            ext_bclk = 1'b0;
        end
    end

    sac_clock_chain dut (
        .clk(clk), .rst_n(rst_n), .en(en), .net_clk(net_clk), .net_tick(net_tick),
        .wl_sel(wl_sel), .psr(psr), .pm(pm), .frm_m1(frm_m1), .bclk_int(bclk_int),
        .fs_int(fs_int), .sync_mode(sync_mode), .nclk_oe(nclk_oe), .ext_bclk(ext_bclk),
        .ext_fs(ext_fs), .bclk_o(bclk_o), .word_stb_o(word_stb_o), .fs_o(fs_o),
        .nclk_o(nclk_o), .cfg_err_o(cfg_err_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    task automatic wait_rise(output int t);
        bit last = fs_o;
        bit done = 0;
        int guard = 0;
        while (!done) begin
            @(negedge clk);
            if (fs_o && !last) done = 1;
            last = fs_o;
            guard++;
            if (!done && guard > 20000) begin
                check(0, "R3 frame sync timeout", guard, 0);
                done = 1;
            end
        end
        t = cyc;
    endtask

    task automatic measure_frame(output int per, output int nstb, output int nhigh, output int nfs);
        bit last = 1;
        bit done = 0;
        per = 0; nstb = 0; nhigh = 0; nfs = 0;
        while (!done) begin
            @(negedge clk);
            per++;
            nstb  += int'(word_stb_o);
            nhigh += int'(bclk_o);
            nfs   += int'(fs_o);
            if (fs_o && !last) done = 1;
            last = fs_o;
            if (per > 20000) done = 1;
        end
    endtask

    task automatic setup(input int div, input bit p, input int m, input int wls,
                         input int fm, input bit bi, input bit fi);
        @(negedge clk);
        en = 1'b0;
        repeat (3) @(negedge clk);
        net_div = div; psr = p; pm = 8'(m); wl_sel = 3'(wls);
        frm_m1 = 5'(fm); bclk_int = bi; fs_int = fi;
        @(negedge clk);
        en = 1'b1;
    endtask

    task automatic run_frame(input string tag, input int f, input int ns, input int b);
        int t, per, nstb, nhigh, nfs;
        wait_rise(t);
        measure_frame(per, nstb, nhigh, nfs);
        chk_eq({tag, " R2 frame period"}, per, f);
        chk_eq({tag, " R1 word strobes"}, nstb, ns);
        chk_eq({tag, " R3 sync width"}, nfs, b);
        chk_eq({tag, " R4 bclk high"}, nhigh, f / 2);
    endtask

    task automatic t_reset;
        chk_eq("R11 bclk", int'(bclk_o), 0);
        chk_eq("R11 fs", int'(fs_o), 0);
        chk_eq("R11 stb", int'(word_stb_o), 0);
        chk_eq("R11 nclk", int'(nclk_o), 0);
        chk_eq("R11 err", int'(cfg_err_o), 0);
    endtask

    task automatic t_basic;
        int t0, t1, per, nstb, nhigh, nfs;
        setup(1, 0, 3, 0, 1, 1, 1);
        t0 = cyc;
        wait_rise(t1);
        check((t1 - t0) >= 128 && (t1 - t0) <= 140, "R3 first sync after full frame", t1 - t0, 128);
        measure_frame(per, nstb, nhigh, nfs);
        chk_eq("R2 period 8b x2", per, 128);
        chk_eq("R1 strobes 8b x2", nstb, 2);
        chk_eq("R3 width", nfs, 8);
        chk_eq("R4 duty", nhigh, 64);
    endtask

    task automatic t_variants;
        setup(1, 1, 0, 1, 0, 1, 1);
        run_frame("psr 10b", 160, 1, 16);
        setup(3, 0, 1, 7, 0, 1, 1);
        run_frame("div3 24b", 288, 1, 12);
        setup(1, 0, 0, 0, 31, 1, 1);
        run_frame("32 words", 512, 32, 2);
    endtask

    task automatic t_shadow;
        int ta, tb, per, nstb, nhigh, nfs;
        setup(1, 0, 2, 0, 0, 1, 1);
        wait_rise(ta);
        repeat (10) @(negedge clk);
        wl_sel = 3'd3;
        frm_m1 = 5'd1;
        wait_rise(tb);
        chk_eq("R9 current frame kept", tb - ta, 48);
        measure_frame(per, nstb, nhigh, nfs);
        chk_eq("R9 next frame applied", per, 192);
        chk_eq("R9 next frame strobes", nstb, 2);
    endtask

    task automatic t_disable;
        int bad = 0;
        @(negedge clk);
        en = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (bclk_o || fs_o || word_stb_o) bad++;
        end
        chk_eq("R10 outputs quiet while disabled", bad, 0);
    endtask

    task automatic t_cfg_err;
        @(negedge clk);
        en = 1'b1; bclk_int = 1'b1; psr = 1'b0; pm = 8'd1;
        #1 chk_eq("R8 period 4", int'(cfg_err_o), 1);
        pm = 8'd2;
        #1 chk_eq("R8 period 6", int'(cfg_err_o), 0);
        pm = 8'd0; psr = 1'b1;
        #1 chk_eq("R8 psr period 16", int'(cfg_err_o), 0);
        psr = 1'b0; bclk_int = 1'b0;
        #1 chk_eq("R8 external clock", int'(cfg_err_o), 0);
    endtask

    task automatic t_nclk;
        @(negedge clk);
        en = 1'b1; bclk_int = 1'b1; fs_int = 1'b1; sync_mode = 1'b1; nclk_oe = 1'b1; pm = 8'd3;
        net_clk = 1'b1;
        #1 chk_eq("R7 forward high", int'(nclk_o), 1);
        net_clk = 1'b0;
        #1 chk_eq("R7 forward low", int'(nclk_o), 0);
        net_clk = 1'b1; nclk_oe = 1'b0;
        #1 chk_eq("R7 oe off", int'(nclk_o), 0);
        nclk_oe = 1'b1; sync_mode = 1'b0;
        #1 chk_eq("R7 async", int'(nclk_o), 0);
        sync_mode = 1'b1; fs_int = 1'b0;
        #1 chk_eq("R7 slave frame", int'(nclk_o), 0);
        net_clk = 1'b0; fs_int = 1'b1;
    endtask

    task automatic t_ext_bclk;
        setup(1, 0, 3, 0, 0, 0, 1);
        ext_run = 1'b1;
        run_frame("R5 ext bclk", 80, 1, 10);
        ext_run = 1'b0;
    endtask

    task automatic t_ext_fs;
        int ts, tw, guard;
        setup(1, 0, 3, 0, 0, 1, 0);
        repeat (20) @(negedge clk);
        ext_fs = 1'b1;
        ts = cyc;
        repeat (4) @(negedge clk);
        chk_eq("R6 fs follows pin high", int'(fs_o), 1);
        guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!word_stb_o && guard < 500);
        tw = cyc;
        check((tw - ts) >= 56 && (tw - ts) <= 72, "R6 restart to next strobe", tw - ts, 64);
        ext_fs = 1'b0;
        repeat (4) @(negedge clk);
        chk_eq("R6 fs follows pin low", int'(fs_o), 0);
    endtask

    initial begin
        rst_n = 1'b0; en = 1'b0; net_clk = 1'b0; wl_sel = '0; psr = 1'b0; pm = '0;
        frm_m1 = '0; bclk_int = 1'b1; fs_int = 1'b1; sync_mode = 1'b0; nclk_oe = 1'b0;
        ext_fs = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_basic();
        t_variants();
        t_shadow();
        t_disable();
        t_basic();
        t_cfg_err();
        t_nclk();
        t_ext_bclk();
        t_ext_fs();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule